// File: doc/BRIEF.md
# Expired Unused Prefetch Monitor

This block keeps per-line bookkeeping for a set-associative first-level cache built from cells that hold their contents for a limited time only. It tracks four things for every line: whether the line is valid, whether it was brought in by the prefetcher, whether it has been referenced since it was filled, and a coarse age. The age is advanced by a global time tick. When a line's age reaches the selected retention period, the line is dropped.

Several counters help judge whether the retention period and the prefetch distance suit the running workload. One counts prefetched lines that time out without ever being used. One counts all prefetch fills, so software can form the ratio of wasted prefetches. One counts accesses that would have hit if the line had not timed out. One counts demand accesses. All counters restart when a profiling window begins. The data array, the tag compare and the prefetch engine sit outside the block. Only their event strobes, together with the set and way indices, arrive here.

Top module: `evp_monitor`

## Requirements
- R1: After reset every line is invalid and never-expired, all four counters read 0, and `hitOut` and `expMissOut` are low.
- R2: A fill (`fillValid`) makes the addressed line valid. It sets the line's age to 0, clears its referenced flag and its expired flag, and records `fillPf` as its prefetch flag. `pfFillCount` goes up by one on the clock edge that takes a fill with `fillPf` = 1. A demand fill does not change it.
- R3: An access (`accValid`) with `accTagMatch` = 1 to a line that is valid before the edge raises `hitOut` for exactly the following cycle and marks the line referenced.
- R4: On each edge that has `tick` = 1, every valid line that is not being filled advances its age. The age saturates at 255. A line whose advanced age is at least the threshold is invalidated and marked expired. The threshold depends on `retSel`: 0 gives 5, 1 gives 10, 2 gives 15, 3 gives 20, and any value from 4 to 7 gives 200. These are the periods 25, 50, 75 and 100 µs and 1 ms divided by a 5 µs tick.
- R5: On a tick edge, `expUnusedCount` rises by the number of lines that expire with the prefetch flag set and the referenced flag clear. A hit on that line in the same cycle counts as a reference.
- R6: An access with `accTagMatch` = 1 to an invalid line that is marked expired raises `expMissOut` for the following cycle and increments `expMissCount` on the same edge. A tag match on a line that was never filled gives neither a hit nor an expiration miss.
- R7: Refilling a line that holds an unreferenced prefetch before it expires does not change `expUnusedCount`.
- R8: `demandCount` rises by one on every edge that has `accValid` = 1, whatever the tag match result.
- R9: A cycle with `winStart` = 1 makes all four counters read 0 after its edge. No event in that same cycle is counted.
- R10: Every counter saturates at 65535 (2^CNT_W − 1) instead of wrapping.
- R11: Every event in a cycle sees the line state from before the edge. A fill that lands on a line in the same cycle as the tick that would expire it replaces the line, and the old contents are not counted as expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Global age-advance strobe |
| retSel | input | 3 | Retention period select |
| winStart | input | 1 | Profiling window start, clears counters |
| fillValid | input | 1 | Line fill strobe |
| fillPf | input | 1 | Fill was issued by the prefetcher |
| fillSet | input | 7 | Set index of the fill |
| fillWay | input | 2 | Way index of the fill |
| accValid | input | 1 | Demand access strobe |
| accTagMatch | input | 1 | Tag of the accessed way matched |
| accSet | input | 7 | Set index of the access |
| accWay | input | 2 | Way index of the access |
| hitOut | output | 1 | Access hit a live line, one cycle later |
| expMissOut | output | 1 | Access found a timed-out line, one cycle later |
| pfFillCount | output | 16 | Prefetch fills in this window |
| expUnusedCount | output | 16 | Prefetched lines expired unreferenced |
| expMissCount | output | 16 | Expiration misses in this window |
| demandCount | output | 16 | Demand accesses in this window |

## Verification
Each result is registered once. The hit and expiration-miss pulses appear in the cycle right after the access. Every counter shows the effect of a cycle's events after that cycle's clock edge. An expiry is therefore visible in `expUnusedCount`, and as an expiration miss on a later access, one edge after the tick that ages the line past the threshold. The bench changes its inputs just after a falling edge and compares every output at the next falling edge, against a model that it advanced for that one rising edge. Directed sequences count ticks up to exactly the threshold and one tick short of it, so that an off-by-one in the age compare shows up at a known cycle.

// File: rtl/evp_pkg.sv
`timescale 1ns/1ps
package evp_pkg;
  localparam int AGE_W  = 8;
  localparam int LIDX_W = 16;

  typedef logic [AGE_W-1:0]  age_t;
  typedef logic [LIDX_W-1:0] lidx_t;

  // strobes handed from control to the line datapath
  typedef struct packed {
    logic  fill;
    logic  fillPf;
    lidx_t fillIdx;
    logic  acc;
    logic  accMatch;
    lidx_t accIdx;
    logic  tick;
    logic  clr;
    age_t  thr;
  } evpStb_t;

  function automatic age_t ticksFor(input int periodUs, input int tickNs);
    int t;
    t = (periodUs * 1000) / tickNs;
    if (t < 1) t = 1;
    if (t > (2 ** AGE_W) - 1) t = (2 ** AGE_W) - 1;
    return age_t'(t);
  endfunction
endpackage

// File: rtl/evp_ctrl.sv
`timescale 1ns/1ps
module evp_ctrl
  import evp_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  parameter int TICK_NS  = 5000,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             tick,
  input  logic [2:0]       retSel,
  input  logic             winStart,
  input  logic             fillValid,
  input  logic             fillPf,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic             accValid,
  input  logic             accTagMatch,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  output evpStb_t          stb
);
  localparam age_t THR_A = ticksFor(25,   TICK_NS);
  localparam age_t THR_B = ticksFor(50,   TICK_NS);
  localparam age_t THR_C = ticksFor(75,   TICK_NS);
  localparam age_t THR_D = ticksFor(100,  TICK_NS);
  localparam age_t THR_E = ticksFor(1000, TICK_NS);

  age_t thrSel;

  always_comb begin
    unique case (retSel)
      3'd0:    thrSel = THR_A;
      3'd1:    thrSel = THR_B;
      3'd2:    thrSel = THR_C;
      3'd3:    thrSel = THR_D;
      default: thrSel = THR_E;
    endcase
  end

  always_comb begin
    stb.fill     = fillValid;
    stb.fillPf   = fillPf;
    stb.fillIdx  = LIDX_W'(fillSet) * LIDX_W'(NUM_WAYS) + LIDX_W'(fillWay);
    stb.acc      = accValid;
    stb.accMatch = accTagMatch;
    stb.accIdx   = LIDX_W'(accSet) * LIDX_W'(NUM_WAYS) + LIDX_W'(accWay);
    stb.tick     = tick;
    stb.clr      = winStart;
    stb.thr      = thrSel;
  end
endmodule

// File: rtl/evp_lines.sv
`timescale 1ns/1ps
module evp_lines
  import evp_pkg::*;
#(
  parameter int NUM_LINES = 512,
  localparam int INC_W    = $clog2(NUM_LINES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  evpStb_t          stb,
  output logic             expMissNow,
  output logic [INC_W-1:0] unusedNum,
  output logic             hitQ,
  output logic             expMissQ
);
  localparam age_t AGE_MAX = '1;

  logic lineValid [NUM_LINES];
  logic linePf    [NUM_LINES];
  logic lineRef   [NUM_LINES];
  logic lineExp   [NUM_LINES];
  age_t lineAge   [NUM_LINES];

  logic [NUM_LINES-1:0] hitVec;
  logic [NUM_LINES-1:0] missVec;
  logic [NUM_LINES-1:0] unusedVec;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic fillThis;
    logic accThis;
    logic hitThis;
    logic dies;
    age_t ageInc;

    assign fillThis = stb.fill && (stb.fillIdx == LIDX_W'(i));
    assign accThis  = stb.acc && stb.accMatch && (stb.accIdx == LIDX_W'(i));
    assign hitThis  = accThis && lineValid[i];
    assign ageInc   = (lineAge[i] == AGE_MAX) ? AGE_MAX : lineAge[i] + 1'b1;
    assign dies     = stb.tick && lineValid[i] && !fillThis && (ageInc >= stb.thr);

    assign hitVec[i]    = hitThis;
    assign missVec[i]   = accThis && !lineValid[i] && lineExp[i];
    assign unusedVec[i] = dies && linePf[i] && !lineRef[i] && !hitThis;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid[i] <= 1'b0;
        linePf[i]    <= 1'b0;
        lineRef[i]   <= 1'b0;
        lineExp[i]   <= 1'b0;
        lineAge[i]   <= '0;
      end else if (fillThis) begin
        lineValid[i] <= 1'b1;
        linePf[i]    <= stb.fillPf;
        lineRef[i]   <= 1'b0;
        lineExp[i]   <= 1'b0;
        lineAge[i]   <= '0;
      end else begin
        if (hitThis) lineRef[i] <= 1'b1;
        if (dies) begin
          lineValid[i] <= 1'b0;
          lineExp[i]   <= 1'b1;
        end else if (stb.tick && lineValid[i]) begin
          lineAge[i] <= ageInc;
        end
      end
    end
  end

  always_comb begin
    unusedNum = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      unusedNum = unusedNum + INC_W'(unusedVec[k]);
    end
  end

  assign expMissNow = |missVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ     <= 1'b0;
      expMissQ <= 1'b0;
    end else begin
      hitQ     <= |hitVec;
      expMissQ <= expMissNow;
    end
  end
endmodule

// File: rtl/evp_tally.sv
`timescale 1ns/1ps
module evp_tally #(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 16,
  parameter int INC_W   = 10
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            clr,
  input  logic [NUM_CNT-1:0][INC_W-1:0]   inc,
  output logic [NUM_CNT-1:0][CNT_W-1:0]   cnt
);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] CAP = SUM_W'({CNT_W{1'b1}});

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(cnt[c]) + SUM_W'(inc[c]);

    always_ff @(posedge clk) begin
      if (!rstN || clr) cnt[c] <= '0;
      else if (sum > CAP) cnt[c] <= '1;
      else cnt[c] <= sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/evp_monitor.sv
`timescale 1ns/1ps
module evp_monitor
  import evp_pkg::*;
#(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 16,
  parameter int TICK_NS  = 5000,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [2:0]       retSel,
  input  logic             winStart,
  input  logic             fillValid,
  input  logic             fillPf,
  input  logic [SET_W-1:0] fillSet,
  input  logic [WAY_W-1:0] fillWay,
  input  logic             accValid,
  input  logic             accTagMatch,
  input  logic [SET_W-1:0] accSet,
  input  logic [WAY_W-1:0] accWay,
  output logic             hitOut,
  output logic             expMissOut,
  output logic [CNT_W-1:0] pfFillCount,
  output logic [CNT_W-1:0] expUnusedCount,
  output logic [CNT_W-1:0] expMissCount,
  output logic [CNT_W-1:0] demandCount
);
  localparam int NUM_LINES = NUM_SETS * NUM_WAYS;
  localparam int INC_W     = $clog2(NUM_LINES + 1);

  evpStb_t stb;
  logic expMissNow;
  logic [INC_W-1:0] unusedNum;
  logic [3:0][INC_W-1:0] incVec;
  logic [3:0][CNT_W-1:0] cntVec;

  evp_ctrl #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TICK_NS(TICK_NS)) u_ctrl (
    .tick(tick), .retSel(retSel), .winStart(winStart),
    .fillValid(fillValid), .fillPf(fillPf), .fillSet(fillSet), .fillWay(fillWay),
    .accValid(accValid), .accTagMatch(accTagMatch), .accSet(accSet), .accWay(accWay),
    .stb(stb)
  );

  evp_lines #(.NUM_LINES(NUM_LINES)) u_lines (
    .clk(clk), .rstN(rstN), .stb(stb),
    .expMissNow(expMissNow), .unusedNum(unusedNum),
    .hitQ(hitOut), .expMissQ(expMissOut)
  );

  assign incVec[0] = INC_W'(stb.fill && stb.fillPf);
  assign incVec[1] = unusedNum;
  assign incVec[2] = INC_W'(expMissNow);
  assign incVec[3] = INC_W'(stb.acc);

  evp_tally #(.NUM_CNT(4), .CNT_W(CNT_W), .INC_W(INC_W)) u_tally (
    .clk(clk), .rstN(rstN), .clr(stb.clr), .inc(incVec), .cnt(cntVec)
  );

  assign pfFillCount    = cntVec[0];
  assign expUnusedCount = cntVec[1];
  assign expMissCount   = cntVec[2];
  assign demandCount    = cntVec[3];
endmodule

// File: rtl/evp_checker.sv
`timescale 1ns/1ps
module evp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             winStart,
  input logic             fillValid,
  input logic             fillPf,
  input logic             accValid,
  input logic             hitOut,
  input logic             expMissOut,
  input logic [CNT_W-1:0] pfFillCount,
  input logic [CNT_W-1:0] expUnusedCount,
  input logic [CNT_W-1:0] expMissCount,
  input logic [CNT_W-1:0] demandCount
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(hitOut && expMissOut));

  // R9
  win_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    winStart |=> (pfFillCount == '0 && expUnusedCount == '0 &&
                  expMissCount == '0 && demandCount == '0));

  // R8
  demand_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !winStart && demandCount != TOP) |=>
      (demandCount == $past(demandCount) + 1'b1));

  // R2
  pf_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && fillPf && !winStart && pfFillCount != TOP) |=>
      (pfFillCount == $past(pfFillCount) + 1'b1));

  // R2
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(fillValid && fillPf) && !winStart) |=> $stable(pfFillCount));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !winStart |=> (expUnusedCount >= $past(expUnusedCount)));

  // R10
  demand_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (demandCount == TOP && !winStart) |=> (demandCount == TOP));
endmodule

bind evp_monitor evp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .winStart(winStart), .fillValid(fillValid),
  .fillPf(fillPf), .accValid(accValid), .hitOut(hitOut), .expMissOut(expMissOut),
  .pfFillCount(pfFillCount), .expUnusedCount(expUnusedCount),
  .expMissCount(expMissCount), .demandCount(demandCount)
);

// File: tb/sim_evp_monitor.sv
`timescale 1ns/1ps
module sim_evp_monitor;
  localparam int ML   = 16;      // modelled lines: sets 0..3, 4 ways
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [2:0] retSel = 3'd0;
  logic winStart = 1'b0;
  logic fillValid = 1'b0, fillPf = 1'b0;
  logic [6:0] fillSet = '0;
  logic [1:0] fillWay = '0;
  logic accValid = 1'b0, accTagMatch = 1'b0;
  logic [6:0] accSet = '0;
  logic [1:0] accWay = '0;
  logic hitOut, expMissOut;
  logic [15:0] pfFillCount, expUnusedCount, expMissCount, demandCount;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  bit mV [ML];
  bit mP [ML];
  bit mR [ML];
  bit mX [ML];
  int mA [ML];
  bit eHit, eMiss;
  int ePf, eUn, eMs, eDm;

  always #4 clk = ~clk;

  evp_monitor u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .retSel(retSel), .winStart(winStart),
    .fillValid(fillValid), .fillPf(fillPf), .fillSet(fillSet), .fillWay(fillWay),
    .accValid(accValid), .accTagMatch(accTagMatch), .accSet(accSet), .accWay(accWay),
    .hitOut(hitOut), .expMissOut(expMissOut), .pfFillCount(pfFillCount),
    .expUnusedCount(expUnusedCount), .expMissCount(expMissCount),
    .demandCount(demandCount)
  );

  function automatic int thrOf(input int rs);
    case (rs)
      0: return 5;
      1: return 10;
      2: return 15;
      3: return 20;
      default: return 200;
    endcase
  endfunction

  function automatic int satAdd(input int a, input int b);
    return (a + b > CMAX) ? CMAX : a + b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R3", "hitOut", int'(hitOut), int'(eHit));
    chk("R6", "expMissOut", int'(expMissOut), int'(eMiss));
    chk("R2", "pfFillCount", int'(pfFillCount), ePf);
    chk("R5", "expUnusedCount", int'(expUnusedCount), eUn);
    chk("R6", "expMissCount", int'(expMissCount), eMs);
    chk("R8", "demandCount", int'(demandCount), eDm);
  endtask

  // drive one cycle, advance the model by one edge, compare at next falling edge
  task automatic step(input bit t, input int rs, input bit ws,
                      input bit fv, input bit fp, input int fs, input int fw,
                      input bit av, input bit am, input int as_, input int aw);
    int fi, ai, thr, un, na;
    bit hitHere;
    tick = t; retSel = 3'(rs); winStart = ws;
    fillValid = fv; fillPf = fp; fillSet = 7'(fs); fillWay = 2'(fw);
    accValid = av; accTagMatch = am; accSet = 7'(as_); accWay = 2'(aw);
    fi = fs * 4 + fw;
    ai = as_ * 4 + aw;
    thr = thrOf(rs);
    eHit = av && am && mV[ai];
    eMiss = av && am && !mV[ai] && mX[ai];
    un = 0;
    for (int i = 0; i < ML; i++) begin
      if (fv && i == fi) begin
        mV[i] = 1; mP[i] = fp; mR[i] = 0; mX[i] = 0; mA[i] = 0;
      end else begin
        hitHere = av && am && (i == ai) && mV[i];
        if (t && mV[i]) begin
          na = (mA[i] >= 255) ? 255 : mA[i] + 1;
          if (na >= thr) begin
            if (mP[i] && !mR[i] && !hitHere) un++;
            mV[i] = 0; mX[i] = 1;
          end else mA[i] = na;
        end
        if (hitHere) mR[i] = 1;
      end
    end
    if (ws) begin
      ePf = 0; eUn = 0; eMs = 0; eDm = 0;
    end else begin
      ePf = satAdd(ePf, int'(fv && fp));
      eUn = satAdd(eUn, un);
      eMs = satAdd(eMs, int'(eMiss));
      eDm = satAdd(eDm, int'(av));
    end
    @(negedge clk);
    compareAll();
  endtask

  int curSel = 0;
  task automatic idle(input bit t);
    step(t, curSel, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic pfill(input bit pf, input int s, input int w);
    step(0, curSel, 0, 1, pf, s, w, 0, 0, 0, 0);
  endtask
  task automatic access(input int s, input int w);
    step(0, curSel, 0, 0, 0, 0, 0, 1, 1, s, w);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int keep;
    void'($urandom(32'd20240611));
    for (int i = 0; i < ML; i++) begin
      mV[i] = 0; mP[i] = 0; mR[i] = 0; mX[i] = 0; mA[i] = 0;
    end
    eHit = 0; eMiss = 0; ePf = 0; eUn = 0; eMs = 0; eDm = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "hitOut", int'(hitOut), 0);
    chk("R1", "expMissOut", int'(expMissOut), 0);
    chk("R1", "counters", int'(pfFillCount | expUnusedCount | expMissCount | demandCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    compareAll();

    // R4 R5: prefetched line expires unused on the 5th tick
    curSel = 0;
    pfill(1, 0, 0);
    repeat (4) idle(1);
    chk("R4", "not yet expired", int'(expUnusedCount), 0);
    idle(1);
    chk("R5", "expired unused", int'(expUnusedCount), 1);
    // R6: expiration miss on later access
    access(0, 0);
    chk("R6", "expMissOut pulse", int'(expMissOut), 1);
    chk("R6", "expMissCount", int'(expMissCount), 1);
    // R6: never-filled line
    access(0, 3);
    chk("R6", "never filled hit", int'(hitOut), 0);
    chk("R6", "never filled miss", int'(expMissOut), 0);

    // R3: hit on prefetched line marks it used
    pfill(1, 2, 0);
    access(2, 0);
    chk("R3", "hitOut", int'(hitOut), 1);
    keep = int'(expUnusedCount);
    repeat (5) idle(1);
    chk("R3", "referenced not counted", int'(expUnusedCount), keep);

    // R7: replacement of unreferenced prefetch
    pfill(1, 1, 1);
    pfill(0, 1, 1);
    repeat (6) idle(1);
    chk("R7", "evicted not counted", int'(expUnusedCount), keep);

    // R11: fill on the tick that would expire the line
    pfill(1, 1, 0);
    repeat (4) idle(1);
    step(1, curSel, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    chk("R11", "refill wins", int'(expUnusedCount), keep);
    access(1, 0);
    chk("R11", "refilled line hits", int'(hitOut), 1);

    // R4: out-of-range select behaves as 200 ticks
    curSel = 7;
    pfill(0, 3, 1);
    repeat (199) idle(1);
    access(3, 1);
    chk("R4", "alive at 199", int'(hitOut), 1);
    idle(1);
    access(3, 1);
    chk("R4", "expired at 200", int'(expMissOut), 1);

    // R9: window start drops same-cycle events
    step(0, curSel, 1, 1, 1, 0, 2, 1, 0, 0, 0);
    chk("R9", "pfFillCount cleared", int'(pfFillCount), 0);
    chk("R9", "demandCount cleared", int'(demandCount), 0);

    // random mix on sets 0..3
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) curSel = $urandom % 8;
      step(($urandom % 3) == 0, curSel, ($urandom % 300) == 0,
           ($urandom % 4) == 0, $urandom % 2, $urandom % 4, $urandom % 4,
           $urandom % 2, ($urandom % 4) != 0, $urandom % 4, $urandom % 4);
    end

    // R10: saturation of the demand counter
    step(0, curSel, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 65540; n++) step(0, curSel, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    chk("R10", "demandCount saturates", int'(demandCount), CMAX);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule